// File: doc/BRIEF.md
# Split-Byte Converter Result Read Port

This block holds the results of an analog-to-digital converter in a small bank of 16-bit registers. A narrow 8-bit bus reads those results one byte at a time. Because a result is wider than the bus, a new conversion could land between the two byte reads, and the bytes would then belong to different samples. To prevent that, the block keeps one shared 8-bit holding latch. Reading the high byte of any register copies that register's low byte into the latch on the same cycle. A later low-byte read, at any register address, returns the latch and not the live register.

The converter delivers results over a valid/ready stream: a register index and a 10-bit value, taken on every cycle where valid is high. The port never applies back-pressure, so ready stays high outside reset. Each result is stored left-justified in its 16-bit register. A separate word-read path returns all 16 bits of a chosen register in one go and leaves the latch alone.

Software that needs the full result reads the word, or reads the high byte and then the low byte. Software that needs only 8 bits reads the high byte alone.

Top module: `result_byte_port`

## Requirements
- R1: After reset every register reads zero on both paths, and a low-byte read returns zero from the holding latch.
- R2: A stored 10-bit value v appears as a 16-bit word equal to v shifted left by 6: the high byte holds v[9:2], low-byte bits 7..6 hold v[1:0], and low-byte bits 5..0 read zero.
- R3: Byte read address bit 0 selects the byte (0 = high, 1 = low) and bits 2..1 select the register. A high-byte read returns that register's high byte on rd_data in the same cycle as rd_en.
- R4: At the clock edge that ends a high-byte read, the selected register's low byte is copied into the holding latch.
- R5: A low-byte read at any register index returns the holding latch, not that register's live low byte.
- R6: A result written after a high-byte read and before the low-byte read leaves the latch unchanged. The low-byte read still returns the earlier sample.
- R7: While word_en is high, word_data returns the selected register's live 16 bits. It is zero while word_en is low. A word read never changes the holding latch.
- R8: res_ready is high whenever reset is released. A transfer with res_valid high updates the indexed register, and the new value is visible on both read paths from the next cycle.
- R9: If a result write and a high-byte read hit the same register in the same cycle, the read returns the previous high byte and the latch captures the previous low byte.
- R10: rd_data is zero in any cycle where rd_en is low.
- R11: A low-byte read leaves the holding latch unchanged, so repeated low-byte reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Result accepted (always high after reset) |
| res_idx | input | 2 | Destination register index |
| res_value | input | 10 | Conversion result |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 3 | Byte address: register index in bits 2..1, byte select in bit 0 |
| rd_data | output | 8 | Byte read data, combinational with rd_en |
| word_en | input | 1 | Word read strobe |
| word_idx | input | 2 | Register index for word read |
| word_data | output | 16 | Whole register contents |

## Verification
The bench builds the block with its default parameters: four registers, a 10-bit result and an 8-bit bus. With these values the six zero padding bits and the two result bits at the top of the low byte are directly observable, and every register index can be reached. With these values the bench can interleave writes, word reads and byte reads across different registers. It can also land a result write on the very cycle of a high-byte read. This exposes both the latch's same-cycle sampling and its immunity to later writes.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  typedef enum logic {
    BYTE_HI = 1'b0,
    BYTE_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/rbp_bank.sv
module rbp_bank #(
  parameter int NUM_REGS = 4,
  parameter int RES_W    = 10,
  parameter int BUS_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int WORD_W  = 2 * BUS_W,
  localparam int PAD_W   = WORD_W - RES_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_fire,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [RES_W-1:0]                 wr_value,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  words
);
  logic [WORD_W-1:0] justified;
  assign justified = {wr_value, {PAD_W{1'b0}}};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              word_q <= '0;
      else if (wr_fire && wr_idx == IDX_W'(g)) word_q <= justified;
    end
    assign words[g] = word_q;
  end
endmodule

// File: rtl/rbp_temp.sv
module rbp_temp #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/rbp_rdmux.sv
module rbp_rdmux
  import rbp_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BUS_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int WORD_W  = 2 * BUS_W
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
  input  logic [BUS_W-1:0]                tmp_q,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [BUS_W-1:0]                rd_data,
  output logic                            tmp_load,
  output logic [BUS_W-1:0]                tmp_din,
  input  logic                            word_en,
  input  logic [IDX_W-1:0]                word_idx,
  output logic [WORD_W-1:0]               word_data
);
  logic [IDX_W-1:0] sel_idx;
  byte_sel_e        sel_byte;
  logic [WORD_W-1:0] sel_word;

  assign sel_idx  = rd_addr[ADDR_W-1:1];
  assign sel_byte = byte_sel_e'(rd_addr[0]);
  assign sel_word = words[sel_idx];

  always_comb begin
    rd_data  = '0;
    tmp_load = 1'b0;
    tmp_din  = sel_word[BUS_W-1:0];
    if (rd_en) begin
      unique case (sel_byte)
        BYTE_HI: begin
          rd_data  = sel_word[WORD_W-1:BUS_W];
          tmp_load = 1'b1;
        end
        BYTE_LO: rd_data = tmp_q;
      endcase
    end
  end

  assign word_data = word_en ? words[word_idx] : '0;
endmodule

// File: rtl/result_byte_port.sv
module result_byte_port #(
  parameter int NUM_REGS = 4,
  parameter int RES_W    = 10,
  parameter int BUS_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int WORD_W  = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [RES_W-1:0]  res_value,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              word_en,
  input  logic [IDX_W-1:0]  word_idx,
  output logic [WORD_W-1:0] word_data
);
  logic [NUM_REGS-1:0][WORD_W-1:0] words;
  logic [BUS_W-1:0]                tmp_q;
  logic [BUS_W-1:0]                tmp_din;
  logic                            tmp_load;
  logic                            wr_fire;

  assign res_ready = rst_n;
  assign wr_fire   = res_valid && res_ready;

  rbp_bank #(.NUM_REGS(NUM_REGS), .RES_W(RES_W), .BUS_W(BUS_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(res_idx),
    .wr_value(res_value), .words(words)
  );

  rbp_temp #(.BUS_W(BUS_W)) u_temp (
    .clk(clk), .rst_n(rst_n), .load(tmp_load), .din(tmp_din), .q(tmp_q)
  );

  rbp_rdmux #(.NUM_REGS(NUM_REGS), .BUS_W(BUS_W)) u_mux (
    .words(words), .tmp_q(tmp_q), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .tmp_load(tmp_load), .tmp_din(tmp_din),
    .word_en(word_en), .word_idx(word_idx), .word_data(word_data)
  );
endmodule

// File: rtl/rbp_checker.sv
module rbp_checker #(
  parameter int NUM_REGS = 4,
  parameter int RES_W    = 10,
  parameter int BUS_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int WORD_W  = 2 * BUS_W,
  localparam int PAD_W   = WORD_W - RES_W
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            res_ready,
  input logic                            rd_en,
  input logic [ADDR_W-1:0]               rd_addr,
  input logic [BUS_W-1:0]                rd_data,
  input logic                            word_en,
  input logic [WORD_W-1:0]               word_data,
  input logic [BUS_W-1:0]                tmp_q,
  input logic [NUM_REGS-1:0][WORD_W-1:0] words
);
  logic [BUS_W-1:0] addr_lo;
  logic             hi_read;
  assign addr_lo = words[rd_addr[ADDR_W-1:1]][BUS_W-1:0];
  assign hi_read = rd_en && !rd_addr[0];

  // R4: the latch takes the addressed register's low byte after a high-byte read
  a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    hi_read |=> tmp_q == $past(addr_lo));

  // R11 and R7: without a high-byte read the latch holds
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_read |=> $stable(tmp_q));

  // R5: low-byte reads come from the latch
  a_r5_low_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[0]) |-> rd_data == tmp_q);

  // R10: quiet bus when no strobe
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  // R2: padding bits of a word read are zero
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |-> word_data[PAD_W-1:0] == '0);

  // R8: no back-pressure after reset
  a_r8_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready);
endmodule

bind result_byte_port rbp_checker #(
  .NUM_REGS(NUM_REGS), .RES_W(RES_W), .BUS_W(BUS_W)
) u_rbp_checker (
  .clk(clk), .rst_n(rst_n), .res_ready(res_ready), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .word_en(word_en),
  .word_data(word_data), .tmp_q(tmp_q), .words(words)
);

// File: tb/test_result_byte_port.sv
module test_result_byte_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [1:0]  res_idx = '0;
  logic [9:0]  res_value = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        word_en = 1'b0;
  logic [1:0]  word_idx = '0;
  logic [15:0] word_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_word [4];
  logic [7:0]  m_tmp;

  always #4 clk = ~clk;

  result_byte_port i_result_byte_port (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_idx(res_idx), .res_value(res_value), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .word_en(word_en), .word_idx(word_idx), .word_data(word_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    res_valid = 1'b0; rd_en = 1'b0; word_en = 1'b0;
  endtask

  // one operation per cycle: drive after negedge, sample, let posedge take it
  task automatic do_write(input logic [1:0] idx, input logic [9:0] v);
    @(negedge clk);
    res_valid = 1'b1; res_idx = idx; res_value = v;
    #1 chk("R8 ready", {15'd0, res_ready}, 16'd1);
    @(posedge clk); #1 idle_all();
    m_word[idx] = {v, 6'b0};
  endtask

  task automatic do_rd(input logic [1:0] idx, input bit lo, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = {idx, lo};
    #1;
    if (!lo) begin
      chk(req, {8'd0, rd_data}, {8'd0, m_word[idx][15:8]});
      m_tmp = m_word[idx][7:0];
    end else begin
      chk(req, {8'd0, rd_data}, {8'd0, m_tmp});
    end
    @(posedge clk); #1 idle_all();
  endtask

  task automatic do_word(input logic [1:0] idx, input string req);
    @(negedge clk);
    word_en = 1'b1; word_idx = idx;
    #1 chk(req, word_data, m_word[idx]);
    @(posedge clk); #1 idle_all();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      do_rd(2'(i), 1'b0, "R1 reset high byte");
      do_word(2'(i), "R1 reset word");
    end
    do_rd(2'd2, 1'b1, "R1 reset latch");
  endtask

  task automatic t_fill_and_read();
    do_write(2'd0, 10'h3FF);
    do_write(2'd1, 10'h155);
    do_write(2'd2, 10'h2AA);
    do_write(2'd3, 10'h001);
    chk("R2 justify", m_word[1], 16'h5540);
    for (int i = 0; i < 4; i++) begin
      do_rd(2'(i), 1'b0, "R3 high byte");
      do_rd(2'(i), 1'b1, "R4 low after high");
    end
  endtask

  task automatic t_low_any_index();
    do_rd(2'd1, 1'b0, "R3 high reg1");
    do_rd(2'd3, 1'b1, "R5 low via other index");
    do_rd(2'd0, 1'b1, "R5 low via reg0");
  endtask

  task automatic t_write_between();
    do_rd(2'd2, 1'b0, "R3 high reg2");
    do_write(2'd2, 10'h103);
    do_rd(2'd2, 1'b1, "R6 latch keeps old sample");
    do_word(2'd2, "R8 new value on word path");
    do_rd(2'd2, 1'b0, "R8 new high byte");
    do_rd(2'd2, 1'b1, "R6 new low after fresh high");
  endtask

  task automatic t_word_no_touch();
    do_rd(2'd0, 1'b0, "R3 high reg0");
    do_word(2'd3, "R7 word reg3");
    do_word(2'd1, "R7 word reg1");
    do_rd(2'd0, 1'b1, "R7 latch untouched by word read");
    @(negedge clk); #1 chk("R7 word idle zero", word_data, 16'h0000);
  endtask

  task automatic t_collision();
    @(negedge clk);
    res_valid = 1'b1; res_idx = 2'd3; res_value = 10'h2C2;
    rd_en = 1'b1; rd_addr = {2'd3, 1'b0};
    #1 chk("R9 old high byte on collision", {8'd0, rd_data}, {8'd0, m_word[3][15:8]});
    m_tmp = m_word[3][7:0];
    @(posedge clk); #1 idle_all();
    m_word[3] = {10'h2C2, 6'b0};
    do_rd(2'd3, 1'b1, "R9 latch holds old low byte");
    do_word(2'd3, "R9 write still landed");
  endtask

  task automatic t_low_repeat();
    do_rd(2'd1, 1'b0, "R3 high reg1 again");
    do_rd(2'd1, 1'b1, "R11 first low read");
    do_write(2'd1, 10'h0FE);
    do_rd(2'd1, 1'b1, "R11 second low read unchanged");
    do_rd(2'd1, 1'b1, "R11 third low read unchanged");
  endtask

  task automatic t_idle();
    @(negedge clk);
    rd_addr = {2'd0, 1'b0};
    #1 chk("R10 idle bus zero", {8'd0, rd_data}, 16'h0000);
    rd_addr = {2'd0, 1'b1};
    #1 chk("R10 idle bus zero low", {8'd0, rd_data}, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_word[i] = '0;
    m_tmp = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 ready low in reset", {15'd0, res_ready}, 16'd0);
    rst_n = 1'b1;
    t_reset();
    t_fill_and_read();
    t_low_any_index();
    t_write_between();
    t_word_no_touch();
    t_collision();
    t_low_repeat();
    t_idle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule